// File: doc/BRIEF.md
# Serial 110 Pattern Detector

This block takes one serial bit per clock and reports whenever the three most recent bits, oldest first, were 1, 1 and then 0. Matches may overlap. This means a long run of ones followed by a zero still gives exactly one report, on the zero. It fits anywhere a framing or marker pattern has to be found in a bit stream that arrives one bit per cycle.

A single parameter picks one of two builds. The state-only build has four states, and its flag depends only on the stored state. The flag therefore appears in the cycle after the clock edge that samples the closing zero. The input-driven build merges the "pattern complete" state into the idle state, so it needs only three state codes. Its flag is the AND of the "two ones seen" state and a zero on the present input. It therefore rises in the same cycle that the zero is presented, one cycle ahead of the other build.

The input-driven build leaves one of the four 2-bit codes unused. That code leads back to idle with the flag low.

Top module: `pat110_detector`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state returns to idle (code 00 in both builds) and `hit` reads 0 after that edge, whatever the bits were before and whatever the input is.
- R2: In the state-only build (`MEALY_BUILD`=0), `hit` is 1 during the cycle after the edge that sampled a 0 whose two preceding sampled bits were 1 and 1. In every other cycle it is 0.
- R3: Overlap: any run of two or more ones followed by a zero gives exactly one `hit` pulse. The pulse comes from the zero and never from a one.
- R4: In the state-only build, `hit` depends only on the stored state. It holds steady while `bit_in` changes between edges, and it lasts exactly one cycle for each match.
- R5: State-only codes: idle (last bit 0) = 00, one 1 seen = 01, "11" seen = 10, "110" seen = 11. `hit` is 1 only in code 11. The input stream 0110010111010 gives `hit` 0001000000100.
- R6: In the input-driven build (`MEALY_BUILD`=1), `hit` is 1 while `bit_in` is 0 and the two previously sampled bits were 1, 1. It therefore shows a match in the same cycle the closing zero is driven.
- R7: In the input-driven build, `hit` follows `bit_in` within a cycle: in the "11" state it falls as soon as `bit_in` goes to 1 and rises again when it returns to 0, with no clock edge in between.
- R8: Input-driven codes: idle = 00, one 1 seen = 01, "11" seen = 11. Code 10 is never entered after reset. If it were present, `hit` is 0 and the next state is 00.
- R9: Over long random streams, both builds give the same `hit` as a reference that shifts in the last three bits and compares them with 110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data, one bit sampled per rising edge |
| hit | output | 1 | High when the last three bits were 1, 1, 0 (timing depends on build) |

## Verification
The bench builds the block twice, side by side on the same stimulus: once with `MEALY_BUILD`=0 and once with `MEALY_BUILD`=1. It samples the input-driven copy just before each edge and the state-only copy just after it. This makes the one-cycle lead of the input-driven flag directly visible. The state-only copy shows that the flag ignores input changes between edges. The input-driven copy shows that the flag follows the input inside a cycle. Only the input-driven build has a spare code, so its recovery path is within reach only in that build.

// File: rtl/pat110_pkg.sv
package pat110_pkg;

  localparam int ST_W = 2;

  typedef logic [ST_W-1:0] st_t;

  // State-only build: four codes, all used
  localparam st_t MO_IDLE = 2'b00;
  localparam st_t MO_ONE  = 2'b01;
  localparam st_t MO_TWO  = 2'b10;
  localparam st_t MO_SEEN = 2'b11;

  // Input-driven build: three codes, 10 spare
  localparam st_t ML_IDLE  = 2'b00;
  localparam st_t ML_ONE   = 2'b01;
  localparam st_t ML_TWO   = 2'b11;
  localparam st_t ML_SPARE = 2'b10;

  localparam st_t ST_RESET = 2'b00;

endpackage

// File: rtl/pat110_next.sv
module pat110_next
  import pat110_pkg::*;
#(
  parameter bit MEALY_BUILD = 1'b0
) (
  input  st_t  cur,
  input  logic din,
  output st_t  nxt
);

  generate
    if (MEALY_BUILD) begin : g_ml
      always_comb begin
        unique case (cur)
          ML_IDLE:  nxt = din ? ML_ONE : ML_IDLE;
          ML_ONE:   nxt = din ? ML_TWO : ML_IDLE;
          ML_TWO:   nxt = din ? ML_TWO : ML_IDLE;
          // spare code: always back to idle, regardless of input
          default:  nxt = ML_IDLE;
        endcase
      end
    end else begin : g_mo
      always_comb begin
        unique case (cur)
          MO_IDLE:  nxt = din ? MO_ONE : MO_IDLE;
          MO_ONE:   nxt = din ? MO_TWO : MO_IDLE;
          MO_TWO:   nxt = din ? MO_TWO : MO_SEEN;
          default:  nxt = din ? MO_ONE : MO_IDLE;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/pat110_state_reg.sv
module pat110_state_reg
  import pat110_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_t  nxt,
  output st_t  cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_RESET;
    else     cur <= nxt;
  end

endmodule

// File: rtl/pat110_out_moore.sv
module pat110_out_moore
  import pat110_pkg::*;
(
  input  st_t  cur,
  output logic hit
);

  assign hit = (cur == MO_SEEN);

endmodule

// File: rtl/pat110_out_mealy.sv
module pat110_out_mealy
  import pat110_pkg::*;
(
  input  st_t  cur,
  input  logic din,
  output logic hit
);

  // q1 AND NOT input; the spare code 10 also has q1 set, so compare the full code
  assign hit = (cur == ML_TWO) && !din;

endmodule

// File: rtl/pat110_detector.sv
module pat110_detector
  import pat110_pkg::*;
#(
  parameter bit MEALY_BUILD = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit
);

  st_t state_q;
  st_t state_d;

  pat110_next #(.MEALY_BUILD(MEALY_BUILD)) u_next (
    .cur (state_q),
    .din (bit_in),
    .nxt (state_d)
  );

  pat110_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (state_d),
    .cur (state_q)
  );

  generate
    if (MEALY_BUILD) begin : g_out_ml
      pat110_out_mealy u_out (
        .cur (state_q),
        .din (bit_in),
        .hit (hit)
      );
    end else begin : g_out_mo
      pat110_out_moore u_out (
        .cur (state_q),
        .hit (hit)
      );
    end
  endgenerate

endmodule

// File: rtl/pat110_checker.sv
module pat110_checker
  import pat110_pkg::*;
#(
  parameter bit MEALY_BUILD = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic bit_in,
  input logic hit,
  input st_t  st
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st == ST_RESET));

  generate
    if (MEALY_BUILD) begin : g_ml
      p_hit_needs_zero_r6: assert property (@(posedge clk) disable iff (rst)
        hit |-> !bit_in);

      p_hit_after_one_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && !$past(rst)) |-> $past(bit_in));

      p_hit_from_two_r7: assert property (@(posedge clk) disable iff (rst)
        hit |-> (st == ML_TWO));

      p_no_spare_code_r8: assert property (@(posedge clk) disable iff (rst)
        st != ML_SPARE);

      p_spare_recovers_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ML_SPARE) |=> (st == ML_IDLE));
    end else begin : g_mo
      p_hit_after_two_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st) == MO_TWO && !$past(bit_in)) |-> hit);

      p_no_hit_after_one_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bit_in)) |-> !hit);

      p_single_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

      p_seen_code_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st) == MO_SEEN) |-> (st == MO_IDLE || st == MO_ONE));
    end
  endgenerate

endmodule

bind pat110_detector pat110_checker #(.MEALY_BUILD(MEALY_BUILD)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .bit_in (bit_in),
  .hit    (hit),
  .st     (state_q)
);

// File: tb/tb_pat110_detector.sv
module tb_pat110_detector;

  localparam int CLK_HALF = 4;          // 125 MHz
  localparam int N_VEC    = 13;
  localparam int N_RAND   = 3000;

  // {input bit, expected state-only hit, expected input-driven hit}
  localparam logic [2:0] VEC [N_VEC] = '{
    3'b000, 3'b100, 3'b100, 3'b011, 3'b000, 3'b100, 3'b000,
    3'b100, 3'b100, 3'b100, 3'b011, 3'b100, 3'b000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit_mo, hit_ml;
  logic ml_s, mo_s, exp_v;
  logic [2:0] hist;
  int checks = 0;
  int errors = 0;

  always #CLK_HALF clk = ~clk;

  pat110_detector #(.MEALY_BUILD(1'b0)) dut (
    .clk (clk), .rst (rst), .bit_in (bit_in), .hit (hit_mo)
  );

  pat110_detector #(.MEALY_BUILD(1'b1)) dut_ml (
    .clk (clk), .rst (rst), .bit_in (bit_in), .hit (hit_ml)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drive at negedge, sample input-driven copy before the edge, state-only after it
  task automatic step(input logic b, output logic ml, output logic mo);
    @(negedge clk);
    bit_in = b;
    #1 ml = hit_ml;
    @(posedge clk);
    #1 mo = hit_mo;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(2 * CLK_HALF * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset state-only", hit_mo, 1'b0);
    chk("R1 reset input-driven", hit_ml, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R5 / R6: vector table
    for (int i = 0; i < N_VEC; i++) begin
      step(VEC[i][2], ml_s, mo_s);
      chk("R5 table state-only", mo_s, VEC[i][1]);
      chk("R6 table input-driven", ml_s, VEC[i][0]);
    end

    // R3: long run of ones then zero, single pulse
    do_reset();
    for (int i = 0; i < 4; i++) begin
      step(1'b1, ml_s, mo_s);
      chk("R3 ones run state-only", mo_s, 1'b0);
      chk("R3 ones run input-driven", ml_s, 1'b0);
    end
    step(1'b0, ml_s, mo_s);
    chk("R3 closing zero state-only", mo_s, 1'b1);
    chk("R3 closing zero input-driven", ml_s, 1'b1);

    // R4: state-only flag ignores input between edges and lasts one cycle
    bit_in = 1'b1;
    #1 chk("R4 stable on input change", hit_mo, 1'b1);
    step(1'b0, ml_s, mo_s);
    chk("R4 one-cycle pulse", mo_s, 1'b0);
    chk("R3 no second pulse input-driven", ml_s, 1'b0);

    // R7: input-driven flag follows input inside a cycle
    do_reset();
    step(1'b1, ml_s, mo_s);
    step(1'b1, ml_s, mo_s);
    @(negedge clk);
    bit_in = 1'b0;
    #1 chk("R7 zero raises flag", hit_ml, 1'b1);
    bit_in = 1'b1;
    #1 chk("R7 one drops flag", hit_ml, 1'b0);
    bit_in = 1'b0;
    #1 chk("R7 zero raises flag again", hit_ml, 1'b1);
    @(posedge clk);
    #1 chk("R2 state-only follows edge", hit_mo, 1'b1);

    // R1: reset overrides a pending match
    do_reset();
    step(1'b1, ml_s, mo_s);
    step(1'b1, ml_s, mo_s);
    @(negedge clk);
    bit_in = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 reset over match state-only", hit_mo, 1'b0);
    chk("R1 reset over match input-driven", hit_ml, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R8 / R9: random stream against three-bit reference
    do_reset();
    hist = 3'b000;
    void'($urandom(7));
    for (int i = 0; i < N_RAND; i++) begin
      logic b;
      b = 1'($urandom_range(0, 1));
      exp_v = ({hist[1:0], b} == 3'b110);
      step(b, ml_s, mo_s);
      chk("R2/R9 random state-only", mo_s, exp_v);
      chk("R8/R9 random input-driven", ml_s, exp_v);
      hist = {hist[1:0], b};
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule